// File: doc/BRIEF.md
# Serial-Input LFSR Syndrome Register

This block is an n-bit linear feedback shift register that takes one serial data bit on each enabled clock. The bit is XORed with the last stage and the result drives the first stage. Each inner stage whose power appears in the feedback polynomial takes the XOR of the preceding stage and the last stage. The register therefore holds the remainder of the bit stream, read as a polynomial with the first bit as the highest power, divided by the chosen primitive polynomial.

To make parity bits, clear the register, shift in the data, then shift in n zero bits. The register then holds the n parity bits. To check a message, clear the register and shift in the data followed by its parity bits. An intact message leaves all zeros in the register. A single corrupted bit leaves a nonzero syndrome. A combinational flag reports a zero remainder.

The width and the polynomial are elaboration parameters. The default is 8 bits with x^8+x^4+x^3+x^2+1. The block does not supply the bit source and does not sequence the run.

Top module: `lfsr_syn`

## Requirements
- R1: While rst_ni is low, every stage is cleared to zero asynchronously and zero_o is high.
- R2: A rising clock edge with clear_i high loads all zeros, whatever the values of en_i and din_i.
- R3: A rising clock edge with clear_i low and en_i low leaves state_o unchanged.
- R4: An enabled edge (en_i high, clear_i low) loads bit 0 with state_o[n-1] XOR din_i. Each bit k from 1 to n-1 takes state_o[k-1], XORed with state_o[n-1] when x^k is a term of the polynomial. For the default polynomial, bits 2, 3 and 4 are tapped.
- R5: With din_i held at 0 and a nonzero start, the state returns to its start after exactly 2^n-1 enabled edges (255 at the default width). It never becomes zero or repeats earlier.
- R6: After a clear, data followed by n zero bits leaves in state_o the remainder of (data times x^n) modulo the polynomial. These are the parity bits, and state_o[n-1] is the first parity bit to send. Data followed by those parity bits leaves all zeros.
- R7: Data with any single bit flipped, followed by the parity of the unflipped data, leaves a nonzero state.
- R8: zero_o is high in the same cycle exactly when every bit of state_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all stages |
| en_i | input | 1 | Shift enable |
| din_i | input | 1 | Serial data bit |
| state_o | output | WIDTH | Register contents, bit k is stage k+1 |
| zero_o | output | 1 | High when the register is all zeros |

## Verification
Each shift, clear or hold shows on state_o one rising edge after it is driven. zero_o follows state_o in the same cycle with no register between them. The bench changes inputs on the falling edge and samples at the following falling edge, so every comparison falls exactly one edge after its stimulus. The expected remainders come from a polynomial division written in the bench.

// File: rtl/lfsr_syn_pkg.sv
package lfsr_syn_pkg;
  // lower coefficients (x^0..x^(w-1)) of a primitive polynomial of degree w
  function automatic logic [31:0] poly_default(input int w);
    case (w)
      3:       return 32'h3;
      4:       return 32'h3;
      5:       return 32'h5;
      6:       return 32'h3;
      7:       return 32'h3;
      8:       return 32'h1D;
      16:      return 32'h100B;
      default: return 32'h1D;
    endcase
  endfunction
endpackage

// File: rtl/lfsr_syn_cell.sv
module lfsr_syn_cell #(
  parameter bit TAP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic d_i,
  input  logic fb_i,
  output logic q_o
);
  logic d_next;
  assign d_next = d_i ^ (TAP & fb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (clear_i) q_o <= 1'b0;
    else if (en_i)    q_o <= d_next;
  end
endmodule

// File: rtl/lfsr_syn_zero.sv
module lfsr_syn_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);
  assign zero_o = ~|vec_i;
endmodule

// File: rtl/lfsr_syn.sv
module lfsr_syn
  import lfsr_syn_pkg::*;
#(
  parameter int          WIDTH = 8,
  parameter logic [31:0] POLY  = poly_default(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] state_o,
  output logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic             fb;

  assign fb = q[MSB];

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic prev;
    if (k == 0) begin : g_head
      assign prev = din_i;  // serial bit enters beside the x^0 feedback
    end else begin : g_body
      assign prev = q[k-1];
    end
    lfsr_syn_cell #(
      .TAP((k == 0) ? 1'b1 : POLY[k])
    ) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .en_i   (en_i),
      .d_i    (prev),
      .fb_i   (fb),
      .q_o    (q[k])
    );
  end

  lfsr_syn_zero #(.WIDTH(WIDTH)) i_zero (
    .vec_i (q),
    .zero_o(zero_o)
  );

  assign state_o = q;
endmodule

// File: rtl/lfsr_syn_chk.sv
module lfsr_syn_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             en_i,
  input logic             din_i,
  input logic [WIDTH-1:0] state_o,
  input logic             zero_o
);
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (state_o == '0);
  end

  a_r2_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> zero_o);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !en_i) |=> $stable(state_o));

  a_r4_head_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=> state_o[0] == $past(state_o[WIDTH-1] ^ din_i));

  a_r5_nonzero_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && !din_i && !zero_o) |=> !zero_o);

  a_r8_zero_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && !din_i && zero_o) |=> zero_o);
endmodule

bind lfsr_syn lfsr_syn_chk #(.WIDTH(WIDTH)) i_lfsr_syn_chk (.*);

// File: tb/test_lfsr_syn.sv
module test_lfsr_syn;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W:0] PFULL = 9'h11D;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic en_i = 1'b0;
  logic din_i = 1'b0;
  logic [W-1:0] state_o;
  logic zero_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lfsr_syn i_lfsr_syn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .en_i   (en_i),
    .din_i  (din_i),
    .state_o(state_o),
    .zero_o (zero_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // polynomial long division step: append bit, reduce by full polynomial
  function automatic logic [W-1:0] div_step(input logic [W-1:0] r, input logic b);
    logic [W:0] t;
    t = {r, b};
    if (t[W]) t = t ^ PFULL;
    return t[W-1:0];
  endfunction

  task automatic do_clear();
    clear_i = 1'b1; en_i = 1'b1; din_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0; en_i = 1'b0; din_i = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    en_i = 1'b1; din_i = b;
    @(negedge clk_i);
    en_i = 1'b0; din_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 state in reset", state_o, '0);
    check("R1 zero_o in reset", {7'd0, zero_o}, 8'd1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_step_rule();
    logic [W-1:0] prev, exp;
    logic b;
    do_clear();
    for (int i = 0; i < 20; i++) begin
      prev = state_o;
      b = ((i * 7) % 3) == 0;
      // bit0 = msb^din; taps at 2,3,4 take msb
      exp = {prev[W-2:0], 1'b0};
      exp[0] = prev[W-1] ^ b;
      if (prev[W-1]) exp = exp ^ 8'h1C;
      shift_bit(b);
      check("R4 step rule", state_o, exp);
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] snap;
    snap = state_o;
    din_i = 1'b1;
    repeat (3) @(negedge clk_i);
    din_i = 1'b0;
    check("R3 hold with en low", state_o, snap);
  endtask

  task automatic t_clear();
    check("R8 zero_o low when nonzero", {7'd0, zero_o}, {7'd0, state_o == '0});
    do_clear();
    check("R2 clear over enable", state_o, '0);
    check("R8 zero_o high when zero", {7'd0, zero_o}, 8'd1);
  endtask

  task automatic t_period();
    int bad;
    do_clear();
    shift_bit(1'b1);
    check("R5 seed", state_o, 8'h01);
    bad = 0;
    for (int i = 1; i < 255; i++) begin
      shift_bit(1'b0);
      if (state_o == 8'h01 || state_o == 8'h00) bad++;
    end
    check("R5 no early repeat or zero", bad[W-1:0], 8'd0);
    shift_bit(1'b0);
    check("R5 return after 255", state_o, 8'h01);
  endtask

  task automatic run_msg(input logic [23:0] msg, input int flip, input logic [W-1:0] par,
                         input logic use_par);
    do_clear();
    for (int i = 23; i >= 0; i--) shift_bit(msg[i] ^ (i == flip));
    for (int i = W-1; i >= 0; i--) shift_bit(use_par ? par[i] : 1'b0);
  endtask

  task automatic t_parity(input logic [23:0] msg);
    logic [W-1:0] exp;
    logic [W-1:0] par;
    exp = '0;
    for (int i = 23; i >= 0; i--) exp = div_step(exp, msg[i]);
    for (int i = 0; i < W; i++) exp = div_step(exp, 1'b0);
    run_msg(msg, -1, '0, 1'b0);
    check("R6 parity bits", state_o, exp);
    par = state_o;
    run_msg(msg, -1, exp, 1'b1);
    check("R6 message with parity", state_o, '0);
    check("R8 zero_o after good message", {7'd0, zero_o}, 8'd1);
    for (int f = 0; f < 24; f += 5) begin
      run_msg(msg, f, exp, 1'b1);
      check("R7 flipped bit nonzero", {7'd0, state_o != '0}, 8'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_step_rule();
    t_hold();
    t_clear();
    t_period();
    t_parity(24'hC8E5A1);
    t_parity(24'h000001);
    t_parity(24'hFFFFFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule